// File: doc/BRIEF.md
# DMA Address Translator with Register-Resident First Level

This block turns the 32-bit addresses that bus masters issue for DMA into physical addresses. It uses 4 KiB pages. The low 12 address bits pass through unchanged. The translation runs in two steps. The first step looks up a bank of 64 on-chip 32-bit entries, and bus address bits 30:25 pick the entry. Each entry covers 32 MiB and is one of two kinds. A pointer entry points to a second-level table of 8192 four-byte words in memory. A big-page entry maps the whole 32 MiB region directly. The second-level word is fetched through a simple request/response read port. Only one table walk is in flight at a time. An eight-entry fully associative cache keeps completed second-level translations.

Software configures the block through a write-only register port. That port sets the first-level entries, a global enable, a window-size field and an invalidation register. The invalidation register drops cached pages in 16 KiB groups. Requests come in on a valid/ready channel. Each one gets a response that lasts a single cycle and carries either a physical address or a fault. Translation applies only when it is enabled and the address lies inside the window. Any other address passes through unchanged.

Top module: `dxl_top`

## Requirements
- R1: After reset the block has `reqReady`=1, `rspValid`=0 and `memReqValid`=0. Translation is disabled, the window field is 00, every first-level entry is zero and the cache is empty.
- R2: The response is the zero-extended bus address, with no fault and no memory read, in two cases: translation is disabled, or the address is outside the window. Window code 00 covers addresses below 2^28, code 01 covers addresses below 2^31, and codes 10 and 11 cover every 32-bit address.
- R3: Register writes use word indices. Indices 0..63 write first-level entry n, and bus address bits 30:25 select that entry. Index 64 bit 8 is the translation enable. Index 65 bits 1:0 are the window code. A write to index 66 is an invalidation command.
- R4: A first-level entry with bit 31 = 0 and bit 30 = 1 is a pointer. A lookup through it that misses the cache issues exactly one memory read, at address (entry[29:0] << 12) + 4 * bus[24:12]. `memReqAddr` stays stable until `memReqReady` accepts the request.
- R5: A second-level word with bit 31 set gives the physical address {word[29:0], bus[11:0]} and no fault.
- R6: A first-level entry with bits 31:30 = 00 gives a fault with no memory read. A second-level word with bit 31 clear gives a fault and is not cached. A faulting response carries address 0.
- R7: A first-level entry with bit 31 set is a big page. It gives {entry[29:13], bus[24:0]} with no memory read.
- R8: A second-level translation that completes is cached by bus page. A later request to the same page is served without a memory read and returns the cached address even if memory has changed.
- R9: The cache holds 8 pages. After reset, fills go to slots 0, 1, 2, ... in turn and wrap around. A fill replaces whatever page was in its slot.
- R10: Writing value v to index 66 drops every cached page whose bus address shifted right by 14 equals v. Other pages stay cached.
- R11: `reqReady` is low from the cycle after a request is accepted until the response has been given. `rspValid` lasts exactly one cycle, and `memReqValid` is never high while `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrAddr | input | 7 | Register word index |
| cfgWrData | input | 32 | Register write data |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Bus address to translate |
| rspValid | output | 1 | Response valid, one cycle |
| rspAddr | output | 42 | Physical address (0 on fault) |
| rspFault | output | 1 | Translation fault |
| memReqValid | output | 1 | Second-level read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 42 | Byte address of the second-level word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Second-level word |

## Verification
A stale or wrong cache tag shows up at the ports at once. It either removes a memory read the bench expects to count, or adds one it does not expect, on the very next request to that page. A corrupted stored page number appears in `rspAddr` of the same response. A wrong replacement pointer or a failed invalidation only shows when a particular page is revisited. The bench therefore revisits chosen pages right after each fill or invalidation and counts memory reads per request. A control state that gets lost shows up as `reqReady` staying low or `rspValid` never rising within a bounded wait.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } dxl_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // latch incoming bus address
    logic evalLoad;  // load response from register/cache decision
    logic walkLoad;  // load response from fetched second-level word
  } dxl_strobe_t;
endpackage

// File: rtl/dxl_ctrl.sv
module dxl_ctrl
  import dxl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        needWalk,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output dxl_strobe_t stb
);
  dxl_state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNxt = ST_EVAL;
      ST_EVAL:  stateNxt = needWalk ? ST_FETCH : ST_RESP;
      ST_FETCH: if (memReqReady) stateNxt = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNxt = ST_RESP;
      ST_RESP:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  assign reqReady     = (state == ST_IDLE);
  assign memReqValid  = (state == ST_FETCH);
  assign rspValid     = (state == ST_RESP);
  assign stb.capture  = (state == ST_IDLE) && reqValid;
  assign stb.evalLoad = (state == ST_EVAL) && !needWalk;
  assign stb.walkLoad = (state == ST_WAIT) && memRspValid;
endmodule

// File: rtl/dxl_data.sv
module dxl_data
  import dxl_pkg::*;
#(
  parameter int BA_W   = 32,
  parameter int PA_W   = 42,
  parameter int TLB_N  = 8,
  parameter int L1_N   = 64,
  parameter int REG_AW = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dxl_strobe_t       stb,
  input  logic              cfgWrEn,
  input  logic [REG_AW-1:0] cfgWrAddr,
  input  logic [31:0]       cfgWrData,
  input  logic [BA_W-1:0]   reqAddr,
  input  logic [31:0]       memRspData,
  output logic              needWalk,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   rspAddr,
  output logic              rspFault
);
  localparam int PG_SH   = 12;
  localparam int PPN_W   = PA_W - PG_SH;
  localparam int VPN_W   = BA_W - PG_SH;
  localparam int L1_IW   = $clog2(L1_N);
  localparam int REGION  = 25;                  // log2 of 32 MiB
  localparam int L2_IW   = REGION - PG_SH;      // 13 index bits
  localparam int TLB_IW  = $clog2(TLB_N);
  localparam int INV_SH  = 2;                   // 16 KiB granule = page >> 2
  localparam logic [REG_AW-1:0] IDX_CTRL = REG_AW'(L1_N);
  localparam logic [REG_AW-1:0] IDX_WIN  = REG_AW'(L1_N + 1);
  localparam logic [REG_AW-1:0] IDX_INV  = REG_AW'(L1_N + 2);

  logic [31:0]      l1Bank [L1_N];
  logic             xlateEn;
  logic [1:0]       winSel;
  logic [BA_W-1:0]  addrQ;
  logic [PA_W-1:0]  rspAddrQ;
  logic             rspFaultQ;
  logic [TLB_N-1:0] tlbValid;
  logic [VPN_W-1:0] tlbTag [TLB_N];
  logic [PPN_W-1:0] tlbPpn [TLB_N];
  logic [TLB_IW-1:0] rrPtr;

  logic [TLB_N-1:0] hitVec;
  logic [PPN_W-1:0] hitPpn;
  logic             tlbHit, inWin, bypass;
  logic [31:0]      l1e;
  logic             invWr;

  assign invWr = cfgWrEn && (cfgWrAddr == IDX_INV);
  assign l1e   = l1Bank[addrQ[REGION +: L1_IW]];

  always_comb begin
    unique case (winSel)
      2'b00:   inWin = (addrQ[BA_W-1:28] == '0);
      2'b01:   inWin = !addrQ[BA_W-1];
      default: inWin = 1'b1;
    endcase
  end
  assign bypass = !xlateEn || !inWin;

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hitVec[i] = tlbValid[i] && (tlbTag[i] == addrQ[BA_W-1:PG_SH]);
  end

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hitVec[i]) hitPpn |= tlbPpn[i];
  end
  assign tlbHit = |hitVec;

  assign needWalk   = !bypass && !tlbHit && !l1e[31] && l1e[30];
  assign memReqAddr = {l1e[PPN_W-1:0], {PG_SH{1'b0}}}
                    + PA_W'({addrQ[REGION-1:PG_SH], 2'b00});

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < L1_N; i++) l1Bank[i] <= '0;
      xlateEn <= 1'b0;
      winSel  <= 2'b00;
    end else if (cfgWrEn) begin
      if (cfgWrAddr < IDX_CTRL) l1Bank[cfgWrAddr[L1_IW-1:0]] <= cfgWrData;
      if (cfgWrAddr == IDX_CTRL) xlateEn <= cfgWrData[8];
      if (cfgWrAddr == IDX_WIN)  winSel  <= cfgWrData[1:0];
    end
  end

  // request capture and response formation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      rspAddrQ  <= '0;
      rspFaultQ <= 1'b0;
    end else begin
      if (stb.capture) addrQ <= reqAddr;
      if (stb.evalLoad) begin
        rspFaultQ <= 1'b0;
        if (bypass)
          rspAddrQ <= {{(PA_W-BA_W){1'b0}}, addrQ};
        else if (tlbHit)
          rspAddrQ <= {hitPpn, addrQ[PG_SH-1:0]};
        else if (l1e[31])
          rspAddrQ <= {l1e[PPN_W-1:REGION-PG_SH], addrQ[REGION-1:0]};
        else begin
          rspAddrQ  <= '0;
          rspFaultQ <= 1'b1;
        end
      end else if (stb.walkLoad) begin
        rspFaultQ <= !memRspData[31];
        rspAddrQ  <= memRspData[31] ? {memRspData[PPN_W-1:0], addrQ[PG_SH-1:0]} : '0;
      end
    end
  end

  // translation cache: invalidate, then fill (fill wins its own slot)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbValid <= '0;
      rrPtr    <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        tlbTag[i] <= '0;
        tlbPpn[i] <= '0;
      end
    end else begin
      if (invWr)
        for (int i = 0; i < TLB_N; i++)
          if (tlbTag[i][VPN_W-1:INV_SH] == cfgWrData[VPN_W-INV_SH-1:0])
            tlbValid[i] <= 1'b0;
      if (stb.walkLoad && memRspData[31]) begin
        tlbValid[rrPtr] <= 1'b1;
        tlbTag[rrPtr]   <= addrQ[BA_W-1:PG_SH];
        tlbPpn[rrPtr]   <= memRspData[PPN_W-1:0];
        rrPtr           <= rrPtr + 1'b1;
      end
    end
  end

  assign rspAddr  = rspAddrQ;
  assign rspFault = rspFaultQ;
endmodule

// File: rtl/dxl_top.sv
module dxl_top
  import dxl_pkg::*;
#(
  parameter int PA_W   = 42,
  parameter int TLB_N  = 8,
  parameter int REG_AW = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [REG_AW-1:0] cfgWrAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqAddr,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspAddr,
  output logic              rspFault,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData
);
  dxl_strobe_t stb;
  logic        needWalk;

  dxl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needWalk(needWalk),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .reqReady(reqReady), .memReqValid(memReqValid), .rspValid(rspValid),
    .stb(stb)
  );

  dxl_data #(.BA_W(32), .PA_W(PA_W), .TLB_N(TLB_N), .L1_N(64), .REG_AW(REG_AW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .reqAddr(reqAddr), .memRspData(memRspData),
    .needWalk(needWalk), .memReqAddr(memReqAddr), .rspAddr(rspAddr),
    .rspFault(rspFault)
  );
endmodule

// File: rtl/dxl_chk.sv
module dxl_chk #(
  parameter int PA_W = 42
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic [PA_W-1:0] rspAddr,
  input logic            rspFault,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [PA_W-1:0] memReqAddr
);
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);                               // R11
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));                               // R11
  AST_NO_FETCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);                                          // R11
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R4
  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspAddr == '0));                         // R6
endmodule

bind dxl_top dxl_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr)
);

// File: tb/sim_dxl_top.sv
`timescale 1ns/1ps
module sim_dxl_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic [41:0] rspAddr;
  logic        rspFault;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [41:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int nChecks = 0;
  int nFails = 0;
  int fetches = 0;
  logic [41:0] lastMemAddr = '0;
  logic [29:0] epoch = '0;
  bit done = 0;

  always #2 clk = ~clk;

  dxl_top u0 (.*);

  // memory model: word value depends on address and epoch; table index with low nibble F is invalid
  function automatic logic [31:0] l2Word(input logic [41:0] a);
    if (a[5:2] == 4'hF) return 32'h0;
    return {2'b10, a[31:2] ^ epoch};
  endfunction

  function automatic logic [41:0] walkAddr(input logic [29:0] frame, input logic [31:0] bus);
    return {frame, 12'h000} + 42'({bus[24:12], 2'b00});
  endfunction

  function automatic logic [41:0] walkPa(input logic [29:0] frame, input logic [31:0] bus);
    logic [41:0] m;
    m = walkAddr(frame, bus);
    return {m[31:2] ^ epoch, bus[11:0]};
  endfunction

  initial begin : mem_model
    bit pend;
    pend = 0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        memRspValid = 1'b1;
        memRspData  = l2Word(lastMemAddr);
        pend = 0;
      end else if (memReqValid) begin
        lastMemAddr = memReqAddr;
        fetches++;
        pend = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a, output logic [41:0] pa, output logic flt, output int nf);
    int start;
    int waitc;
    start = fetches;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    waitc = 0;
    while (!rspValid && waitc < 100) begin @(negedge clk); waitc++; end
    if (!rspValid) begin
      nChecks++; nFails++;
      $display("FAIL R11 no response actual=0 expected=1");
    end
    pa = rspAddr; flt = rspFault;
    @(negedge clk);
    nf = fetches - start;
  endtask

  task automatic setupTables();
    wr(7'd0, 32'h4000_0100);   // pointer, table frame 0x100
    wr(7'd1, 32'h8246_0003);   // big page, frame 0x0246_0000, flags set
    wr(7'd2, 32'h0000_0000);   // invalid
    wr(7'd3, 32'h4000_2345);   // pointer, table frame 0x2345
    wr(7'd64, 32'h0000_0100);  // enable
    wr(7'd65, 32'h0000_0003);  // whole space
  endtask

  task automatic tReset();
    chk("R1", "reqReady", 64'(reqReady), 64'd1);
    chk("R1", "rspValid", 64'(rspValid), 64'd0);
    chk("R1", "memReqValid", 64'(memReqValid), 64'd0);
  endtask

  task automatic tBypass();
    logic [41:0] pa; logic f; int n;
    xlate(32'h0123_4567, pa, f, n);           // disabled after reset
    chk("R1", "disabled pa", 64'(pa), 64'h0123_4567);
    chk("R2", "disabled fetch", 64'(n), 64'd0);
    wr(7'd64, 32'h0000_0100);
    wr(7'd65, 32'h0000_0000);
    xlate(32'h1000_0000, pa, f, n);
    chk("R2", "win00 outside pa", 64'(pa), 64'h1000_0000);
    chk("R2", "win00 outside fault", 64'(f), 64'd0);
    xlate(32'h0FFF_F000, pa, f, n);           // inside, L1[63..] index 7 is zero
    chk("R3", "win00 inside fault", 64'(f), 64'd1);
    wr(7'd65, 32'h0000_0001);
    xlate(32'h8000_1000, pa, f, n);
    chk("R2", "win01 outside pa", 64'(pa), 64'h8000_1000);
    xlate(32'h7FFF_F000, pa, f, n);
    chk("R3", "win01 inside fault", 64'(f), 64'd1);
    wr(7'd65, 32'h0000_0003);
    xlate(32'hFFFF_F000, pa, f, n);
    chk("R2", "win11 translated fault", 64'(f), 64'd1);
    chk("R6", "L1 invalid no fetch", 64'(n), 64'd0);
  endtask

  task automatic tWalkHit();
    logic [41:0] pa, exp; logic f; int n;
    exp = walkPa(30'h100, 32'h0000_3ABC);
    xlate(32'h0000_3ABC, pa, f, n);
    chk("R4", "walk fetch count", 64'(n), 64'd1);
    chk("R4", "walk mem addr", 64'(lastMemAddr), 64'(walkAddr(30'h100, 32'h0000_3ABC)));
    chk("R5", "walk pa", 64'(pa), 64'(exp));
    chk("R5", "walk fault", 64'(f), 64'd0);
    epoch = 30'h155;                          // memory changes; cache must not see it
    xlate(32'h0000_3123, pa, f, n);
    chk("R8", "hit fetch count", 64'(n), 64'd0);
    chk("R8", "hit pa", 64'(pa), 64'({exp[41:12], 12'h123}));
  endtask

  task automatic tBigFault();
    logic [41:0] pa; logic f; int n;
    xlate(32'h0200_1234, pa, f, n);
    chk("R7", "big pa", 64'(pa), 64'((42'h0246_0000 >> 13) << 25) | 64'h0000_1234);
    chk("R7", "big fetch", 64'(n), 64'd0);
    xlate(32'h0400_0000, pa, f, n);
    chk("R6", "L1 zero fault", 64'(f), 64'd1);
    chk("R6", "L1 zero addr", 64'(pa), 64'd0);
    xlate(32'h0000_F000, pa, f, n);
    chk("R6", "L2 invalid fault", 64'(f), 64'd1);
    chk("R6", "L2 invalid fetch", 64'(n), 64'd1);
    xlate(32'h0000_F000, pa, f, n);
    chk("R6", "L2 invalid not cached", 64'(n), 64'd1);
  endtask

  task automatic tInval();
    logic [41:0] pa; logic f; int n;
    xlate(32'h0600_4000, pa, f, n);
    xlate(32'h0600_5000, pa, f, n);
    xlate(32'h0600_8000, pa, f, n);
    epoch = 30'h2AA;
    wr(7'd66, 32'h0000_1801);                 // 0x0600_4000 >> 14
    xlate(32'h0600_4000, pa, f, n);
    chk("R10", "inval A refetch", 64'(n), 64'd1);
    chk("R10", "inval A new pa", 64'(pa), 64'(walkPa(30'h2345, 32'h0600_4000)));
    xlate(32'h0600_5000, pa, f, n);
    chk("R10", "inval A2 refetch", 64'(n), 64'd1);
    xlate(32'h0600_8000, pa, f, n);
    chk("R10", "other granule kept", 64'(n), 64'd0);
  endtask

  task automatic tRoundRobin();
    logic [41:0] pa; logic f; int n;
    doReset();
    tReset();
    setupTables();
    for (int k = 0; k < 8; k++) begin
      xlate(32'(k) << 12, pa, f, n);
      chk("R9", "fill", 64'(n), 64'd1);
    end
    xlate(32'h0000_0000, pa, f, n);
    chk("R9", "P0 hit while full", 64'(n), 64'd0);
    xlate(32'h0000_8000, pa, f, n);           // replaces slot 0
    chk("R9", "P8 fill", 64'(n), 64'd1);
    xlate(32'h0000_0000, pa, f, n);
    chk("R9", "P0 evicted", 64'(n), 64'd1);   // refill into slot 1
    xlate(32'h0000_2000, pa, f, n);
    chk("R9", "P2 kept", 64'(n), 64'd0);
    xlate(32'h0000_1000, pa, f, n);
    chk("R9", "P1 evicted", 64'(n), 64'd1);
  endtask

  task automatic tStall();
    int waitc;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0000_F000;
    @(negedge clk);
    chk("R11", "ready low after accept", 64'(reqReady), 64'd0);
    reqAddr = 32'h0000_0000;                  // second request held pending
    waitc = 0;
    while (!rspValid && waitc < 50) begin
      if (reqReady) chk("R11", "ready during walk", 64'(reqReady), 64'd0);
      @(negedge clk); waitc++;
    end
    reqValid = 1'b0;
    chk("R11", "first response fault", 64'(rspFault), 64'd1);
    @(negedge clk);
    chk("R11", "single-cycle rsp", 64'(rspValid), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finishRun();
    end
  end

  initial begin : main
    doReset();
    tReset();
    tBypass();
    setupTables();
    tWalkHit();
    tBigFault();
    tInval();
    tStall();
    tRoundRobin();
    done = 1;
    finishRun();
  end
endmodule